// File: doc/BRIEF.md
# Byte-Wide Multichannel Result Readout

This block sits on the device side of a multichannel converter and lets a host read the conversion results over a narrow 8-bit parallel bus. It keeps a bank of result words, one per channel. The conversion engine fills that bank with a single load pulse. The host opens a read frame by pulling chip select low. Each falling edge of the read strobe then places the next byte of the next result on the bus. Every word takes two bytes, and channel 1 comes out first, followed by the remaining channels in ascending order. A static input selects whether the upper or the lower byte of each word goes first.

Alongside the data byte, the block drives a first-data flag. The flag is high only while the two bytes of channel 1 are on the bus, so the host can check its alignment. Both the byte bus and the flag have output enables. The enables turn on when the frame opens and return to high impedance when chip select rises. Chip select and the read strobe are asynchronous to the system clock. Each one passes through a synchronizer, and all output changes are registered in the clock domain.

Top module: `adc_byte_readout`

## Requirements
- R1: While reset is high, and directly after it, `bus_oe`, `first_oe`, `bus_out` and `first_out` are all 0.
- R2: A falling edge on `cs_n` sets `bus_oe` and `first_oe` to 1. A rising edge on `cs_n` clears both to 0.
- R3: Within a frame, each falling edge of `rd_n` drives the next byte. Byte k (0-based) belongs to channel k/2 (channel 1 is index 0, whose word is `results[15:0]`; channel i is `results[16*i+15:16*i]`). All eight channels are covered in sixteen strobes.
- R4: With `msb_first`=1, the first byte of a word is bits [15:8] and the second byte is bits [7:0]. With `msb_first`=0, the order is reversed.
- R5: `msb_first` is sampled at the falling edge of `cs_n`. Changing it during a frame has no effect until the next frame.
- R6: `first_out` is 1 after the first and second read strobes of a frame. It is 0 from the third strobe onward.
- R7: After sixteen strobes, further strobes in the same frame wrap back to channel 1, first byte, and `first_out` stays 0.
- R8: Every falling edge of `cs_n` restarts the sequence at channel 1, first byte, even if the previous frame ended part-way through.
- R9: The result words are captured only while `load` is 1. A load during an open frame does not alter that frame. It becomes visible from the next frame. A change on `results` without `load` is never seen.
- R10: Read strobes while `cs_n` is high leave `bus_out`, `first_out` and both enables unchanged. They do not advance the sequence.
- R11: An output responds to a `cs_n` or `rd_n` edge on the third rising clock edge after the input changes, that is, two synchronizer flops plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, byte advance on falling edge, asynchronous |
| msb_first | input | 1 | Byte order select, 1 means upper byte first |
| load | input | 1 | Capture strobe for the result words |
| results | input | 128 | Eight 16-bit results, channel i at bits [16*i+15:16*i] |
| bus_out | output | 8 | Data byte |
| bus_oe | output | 1 | Output enable of the data byte |
| first_out | output | 1 | First-data flag |
| first_oe | output | 1 | Output enable of the first-data flag |

## Verification
The bench builds the block with its default values: eight channels of 16-bit words, 8-bit bytes and a two-flop synchronizer. With these values the full sixteen-strobe sweep and the wrap on the seventeenth strobe are short enough to cover directly in both byte orders. The two-flop depth also fixes the three-clock response, and the bench checks it at the cycle boundary. With only eight channels, a load can be placed part-way through a frame, and the bench can then show that the old words finish that frame and the new words appear in the next one.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,
    ORDER_HIGH_FIRST = 1'b1
  } byte_order_e;
endpackage

// File: rtl/adc_rd_strobe_sync.sv
module adc_rd_strobe_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level,
  output logic fall,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES+1){IDLE}};
    else     chain <= {chain[STAGES-1:0], raw};
  end

  assign level = chain[STAGES-1];
  assign fall  = chain[STAGES] & ~chain[STAGES-1];
  assign rise  = ~chain[STAGES] & chain[STAGES-1];
endmodule

// File: rtl/adc_rd_result_bank.sv
module adc_rd_result_bank #(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NUM_CH*WORD_W-1:0] results,
  input  logic                     frame_start,
  input  logic [CH_W-1:0]          rd_chan,
  output logic [WORD_W-1:0]        rd_word
);
  // pending holds the last load, frame holds the copy frozen for the open frame
  logic [NUM_CH-1:0][WORD_W-1:0] pending;
  logic [NUM_CH-1:0][WORD_W-1:0] frame;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)       pending[g] <= '0;
      else if (load) pending[g] <= results[g*WORD_W +: WORD_W];
    end
    always_ff @(posedge clk) begin
      if (rst)              frame[g] <= '0;
      else if (frame_start) frame[g] <= pending[g];
    end
  end

  assign rd_word = frame[rd_chan];

  assert_load_only_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(pending));
  assert_frame_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(frame));
endmodule

// File: rtl/adc_rd_sequencer.sv
module adc_rd_sequencer
  import adc_rd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  localparam int BYTES  = WORD_W / BYTE_W,
  localparam int PART_W = $clog2(BYTES),
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int CNT_W  = CH_W + PART_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              rd_fall,
  input  logic              msb_first,
  input  logic [WORD_W-1:0] chan_word,
  output logic [CH_W-1:0]   chan_idx,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              first_out,
  output logic              first_oe
);
  localparam logic [CNT_W-1:0] LAST_CNT = '1;

  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              wrapped;
  byte_order_e       order_q;
  logic [PART_W-1:0] part;
  logic [PART_W-1:0] slice;
  logic [BYTE_W-1:0] picked;
  logic              step;

  assign chan_idx = cnt[CNT_W-1:PART_W];
  assign part     = cnt[PART_W-1:0];
  assign slice    = (order_q == ORDER_HIGH_FIRST) ? (PART_W'(BYTES-1) - part) : part;
  assign picked   = chan_word[slice*BYTE_W +: BYTE_W];
  assign step     = rd_fall && active && !cs_fall && !cs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      active    <= 1'b0;
      wrapped   <= 1'b0;
      order_q   <= ORDER_LOW_FIRST;
      bus_out   <= '0;
      bus_oe    <= 1'b0;
      first_out <= 1'b0;
      first_oe  <= 1'b0;
    end else if (cs_fall) begin
      cnt       <= '0;
      active    <= 1'b1;
      wrapped   <= 1'b0;
      order_q   <= byte_order_e'(msb_first);
      bus_out   <= '0;
      bus_oe    <= 1'b1;
      first_out <= 1'b0;
      first_oe  <= 1'b1;
    end else if (cs_rise) begin
      active    <= 1'b0;
      bus_oe    <= 1'b0;
      first_out <= 1'b0;
      first_oe  <= 1'b0;
    end else if (step) begin
      bus_out   <= picked;
      first_out <= (cnt < CNT_W'(BYTES)) && !wrapped;
      cnt       <= cnt + 1'b1;
      if (cnt == LAST_CNT) wrapped <= 1'b1;
    end
  end

  assert_frame_open_R8: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (bus_oe && first_oe && cnt == '0));
  assert_frame_close_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !cs_fall) |=> (!bus_oe && !first_oe));
  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt == $past(cnt) + 1'b1));
  assert_flag_late_R6: assert property (@(posedge clk) disable iff (rst)
    (step && cnt >= CNT_W'(BYTES)) |=> !first_out);
  assert_wrap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (wrapped && !cs_fall) |=> !first_out);
  assert_order_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_fall |=> $stable(order_q));
  assert_idle_still_R10: assert property (@(posedge clk) disable iff (rst)
    (!active && !cs_fall) |=> ($stable(bus_out) && $stable(cnt)));
endmodule

// File: rtl/adc_byte_readout.sv
module adc_byte_readout #(
  parameter int NUM_CH      = 8,
  parameter int WORD_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     msb_first,
  input  logic                     load,
  input  logic [NUM_CH*WORD_W-1:0] results,
  output logic [BYTE_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic                     first_out,
  output logic                     first_oe
);
  logic cs_level, cs_fall, cs_rise;
  logic rd_level, rd_fall, rd_rise;
  logic [CH_W-1:0]   chan_idx;
  logic [WORD_W-1:0] chan_word;

  adc_rd_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .raw(cs_n),
    .level(cs_level), .fall(cs_fall), .rise(cs_rise));

  adc_rd_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_sync (
    .clk(clk), .rst(rst), .raw(rd_n),
    .level(rd_level), .fall(rd_fall), .rise(rd_rise));

  adc_rd_result_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .load(load), .results(results),
    .frame_start(cs_fall), .rd_chan(chan_idx), .rd_word(chan_word));

  adc_rd_sequencer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .rd_fall(rd_fall), .msb_first(msb_first), .chan_word(chan_word),
    .chan_idx(chan_idx), .bus_out(bus_out), .bus_oe(bus_oe),
    .first_out(first_out), .first_oe(first_oe));

  assert_edges_apart_R11: assert property (@(posedge clk) disable iff (rst)
    rd_fall |=> !rd_fall);
  assert_oe_pair_R2: assert property (@(posedge clk) disable iff (rst)
    bus_oe == first_oe);
  assert_cs_level_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_level && !cs_fall && !cs_rise) |=> !bus_oe);
endmodule

// File: tb/tb_adc_byte_readout.sv
`timescale 1ns/1ps
module tb_adc_byte_readout;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic rd_n = 1'b1;
  logic msb_first = 1'b1;
  logic load = 1'b0;
  logic [NCH*16-1:0] results = '0;
  logic [7:0] bus_out;
  logic bus_oe, first_out, first_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] set_a [NCH];
  logic [15:0] set_b [NCH];

  always #2 clk = ~clk;

  adc_byte_readout dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .msb_first(msb_first),
    .load(load), .results(results), .bus_out(bus_out), .bus_oe(bus_oe),
    .first_out(first_out), .first_oe(first_oe));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [15:0] w, input int k, input bit hi_first);
    bit upper = ((k % 2) == 0) ? hi_first : !hi_first;
    return upper ? w[15:8] : w[7:0];
  endfunction

  task automatic load_set(input bit use_b);
    for (int i = 0; i < NCH; i++) results[i*16 +: 16] = use_b ? set_b[i] : set_a[i];
    load = 1'b1; clks(1); load = 1'b0; clks(1);
  endtask

  task automatic cs_low();  cs_n = 1'b0; clks(5); endtask
  task automatic cs_high(); cs_n = 1'b1; clks(5); endtask

  task automatic rd_pulse(output logic [7:0] b, output logic f);
    rd_n = 1'b0; clks(5);
    b = bus_out; f = first_out;
    rd_n = 1'b1; clks(5);
  endtask

  task automatic t_reset();
    chk(bus_oe == 0 && first_oe == 0, "R1 enables", {14'd0, bus_oe, first_oe}, 16'd0);
    chk(bus_out == 0 && first_out == 0, "R1 data", {7'd0, bus_out, first_out}, 16'd0);
  endtask

  task automatic t_full_read(input bit hi_first, input bit use_b);
    logic [7:0] b; logic f; logic [15:0] w;
    msb_first = hi_first;
    cs_low();
    chk(bus_oe && first_oe, "R2 open", {14'd0, bus_oe, first_oe}, 16'd3);
    for (int k = 0; k < 2*NCH; k++) begin
      rd_pulse(b, f);
      w = use_b ? set_b[k/2] : set_a[k/2];
      chk(b == exp_byte(w, k, hi_first), hi_first ? "R3 R4 high-first" : "R3 R4 low-first",
          {8'd0, b}, {8'd0, exp_byte(w, k, hi_first)});
      chk(f == (k < 2), "R6 flag", {15'd0, f}, {15'd0, k < 2});
    end
    cs_high();
    chk(!bus_oe && !first_oe, "R2 close", {14'd0, bus_oe, first_oe}, 16'd0);
  endtask

  task automatic t_order_latch();
    logic [7:0] b; logic f;
    msb_first = 1'b1;
    cs_low();
    msb_first = 1'b0;
    for (int k = 0; k < 2; k++) begin
      rd_pulse(b, f);
      chk(b == exp_byte(set_a[0], k, 1'b1), "R5 order held", {8'd0, b}, {8'd0, exp_byte(set_a[0], k, 1'b1)});
    end
    cs_high();
    cs_low();
    rd_pulse(b, f);
    chk(b == exp_byte(set_a[0], 0, 1'b0), "R5 new order next frame", {8'd0, b}, {8'd0, exp_byte(set_a[0], 0, 1'b0)});
    cs_high();
  endtask

  task automatic t_wrap();
    logic [7:0] b; logic f;
    msb_first = 1'b1;
    cs_low();
    for (int k = 0; k < 2*NCH; k++) rd_pulse(b, f);
    for (int k = 0; k < 2; k++) begin
      rd_pulse(b, f);
      chk(b == exp_byte(set_a[0], k, 1'b1), "R7 wrap byte", {8'd0, b}, {8'd0, exp_byte(set_a[0], k, 1'b1)});
      chk(f == 1'b0, "R7 flag quiet", {15'd0, f}, 16'd0);
    end
    cs_high();
  endtask

  task automatic t_restart();
    logic [7:0] b; logic f;
    msb_first = 1'b1;
    cs_low();
    for (int k = 0; k < 5; k++) rd_pulse(b, f);
    cs_high();
    cs_low();
    rd_pulse(b, f);
    chk(b == set_a[0][15:8], "R8 restart byte", {8'd0, b}, {8'd0, set_a[0][15:8]});
    chk(f == 1'b1, "R8 restart flag", {15'd0, f}, 16'd1);
    cs_high();
  endtask

  task automatic t_load_mid();
    logic [7:0] b; logic f;
    msb_first = 1'b1;
    cs_low();
    for (int k = 0; k < 4; k++) rd_pulse(b, f);
    load_set(1'b1);
    rd_pulse(b, f);
    chk(b == set_a[2][15:8], "R9 frame keeps old words", {8'd0, b}, {8'd0, set_a[2][15:8]});
    cs_high();
    results = '1;
    clks(2);
    cs_low();
    rd_pulse(b, f);
    chk(b == set_b[0][15:8], "R9 new words next frame", {8'd0, b}, {8'd0, set_b[0][15:8]});
    rd_pulse(b, f);
    chk(b == set_b[0][7:0], "R9 input ignored without load", {8'd0, b}, {8'd0, set_b[0][7:0]});
    cs_high();
  endtask

  task automatic t_idle_rd();
    logic [7:0] b; logic f; logic [7:0] prev;
    prev = bus_out;
    rd_pulse(b, f);
    chk(b == prev && f == 1'b0, "R10 idle data", {8'd0, b}, {8'd0, prev});
    chk(!bus_oe && !first_oe, "R10 idle enables", {14'd0, bus_oe, first_oe}, 16'd0);
    msb_first = 1'b1;
    cs_low();
    rd_pulse(b, f);
    chk(b == set_b[0][15:8], "R10 no advance", {8'd0, b}, {8'd0, set_b[0][15:8]});
    cs_high();
  endtask

  task automatic t_latency();
    cs_n = 1'b0;
    clks(2);
    chk(bus_oe == 1'b0, "R11 not before third edge", {15'd0, bus_oe}, 16'd0);
    clks(1);
    chk(bus_oe == 1'b1, "R11 at third edge", {15'd0, bus_oe}, 16'd1);
    cs_n = 1'b1;
    clks(2);
    chk(bus_oe == 1'b1, "R11 close not early", {15'd0, bus_oe}, 16'd1);
    clks(1);
    chk(bus_oe == 1'b0, "R11 close at third edge", {15'd0, bus_oe}, 16'd0);
    clks(3);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      set_a[i] = 16'hA100 + 16'(i * 16'h0213);
      set_b[i] = 16'h3C00 + 16'(i * 16'h0107) + 16'h0050;
    end
    clks(3);
    @(negedge clk) rst = 1'b0;
    clks(1);
    t_reset();
    load_set(1'b0);
    t_full_read(1'b1, 1'b0);
    t_full_read(1'b0, 1'b0);
    t_order_latch();
    t_wrap();
    t_restart();
    t_load_mid();
    t_full_read(1'b1, 1'b1);
    t_idle_rd();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule